// File: doc/BRIEF.md
# DRAM page crossing detector

This block sits beside the external port of a bus master and watches each outgoing access. An access that targets the DRAM bank is compared with the address of the last access that completed successfully in that bank. When the two fall in different pages, the block raises a page-crossing flag for an external DRAM controller, which can then open a new row. The same flag also masks host bus requests for as long as it is raised. The page size is chosen by a 3-bit code. The page register is cleared out when the master loses the bus or is reset, so the first DRAM access after either event always counts as a crossing.

All inputs are plain level signals, sampled every cycle, and there is no back-pressure. The access fields (valid, address, bank flag, abort) are held stable by the master for the whole access, and `acc_done` marks its final cycle. Both outputs are combinational on the current access, so they follow the access as long as it lasts. The stored address is available on a read-back port that is one register stage behind the page register. The parameters must satisfy BASE_SHIFT + 2^CODE_W - 1 < ADDR_W. If `bus_lost` and a completing access come in the same cycle, `bus_lost` wins and the page is left invalid.

Top module: `dram_page_watch`

## Requirements
- R1: After reset, `page_cross`, `host_req_mask` and `last_addr` are 0, and the first eligible access (valid, bank 0, not aborted) raises `page_cross`.
- R2: An eligible access whose page matches the stored page leaves `page_cross` at 0.
- R3: An eligible access whose page differs from the stored page raises `page_cross` in the same cycle.
- R4: An access with `acc_bank0` low never raises `page_cross` and does not change the stored address.
- R5: An access with `acc_abort` high never raises `page_cross` and does not change the stored address.
- R6: The stored address takes `acc_addr` only at the clock edge where an eligible access has `acc_done` high. A cycle with `acc_done` low stores nothing.
- R7: A `bus_lost` pulse invalidates the stored page, so the next eligible access raises `page_cross` even at the same address. It takes priority over an update in the same cycle.
- R8: A page is 2^(BASE_SHIFT+page_code) words. Only the address bits at position BASE_SHIFT+page_code and above are compared (default BASE_SHIFT=8).
- R9: `host_req_mask` equals `page_cross` in every cycle.
- R10: `last_addr` shows a new stored value one clock after the edge that stored it. In the cycle right after that edge it still shows the previous value.
- R11: `page_cross` stays high in every cycle of a crossing access that lasts several cycles, and it is 0 whenever `acc_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | An external access is in progress |
| acc_addr | input | ADDR_W | Word address of the access |
| acc_abort | input | 1 | Access is aborted (for example, a failed conditional write) |
| acc_done | input | 1 | Final, successful cycle of the access |
| acc_bank0 | input | 1 | Access targets the DRAM bank |
| bus_lost | input | 1 | Pulse: bus mastership given up |
| page_code | input | CODE_W | Page size code, page = 2^(BASE_SHIFT+code) words |
| page_cross | output | 1 | Current access crosses a page |
| host_req_mask | output | 1 | Blocks host bus requests |
| last_addr | output | ADDR_W | Read-back of the stored address |

## Verification
The bench uses the defaults ADDR_W=32, CODE_W=3 and BASE_SHIFT=8. With these, page codes 0, 2 and 7 give pages of 256, 1024 and 32768 words. That puts the lowest and the highest page boundaries next to each other in one run, at addresses that are easy to read. The bench holds an access over several cycles with `acc_done` low, which shows that the flag is held and that nothing is stored. Read-back is checked both in the cycle right after an update and one cycle later.

// File: rtl/dpw_pkg.sv
package dpw_pkg;
  typedef struct packed {
    logic valid;
    logic abort;
    logic done;
    logic bank0;
  } dpw_ctl_t;
endpackage

// File: rtl/dpw_page_cmp.sv
module dpw_page_cmp #(
  parameter int ADDR_W     = 32,
  parameter int CODE_W     = 3,
  parameter int BASE_SHIFT = 8
) (
  input  logic [ADDR_W-1:0] addr_a,
  input  logic [ADDR_W-1:0] addr_b,
  input  logic [CODE_W-1:0] code,
  output logic              same_page
);
  logic [ADDR_W-1:0] diff;
  int                lo_bit;

  assign lo_bit = BASE_SHIFT + int'(code);

  for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
    assign diff[i] = (addr_a[i] ^ addr_b[i]) & (i >= lo_bit);
  end

  assign same_page = ~|diff;
endmodule

// File: rtl/dpw_page_reg.sv
module dpw_page_reg #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd,
  input  logic              inval,
  input  logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] stored,
  output logic              stored_vld,
  output logic [ADDR_W-1:0] readback
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stored     <= '0;
      stored_vld <= 1'b0;
      readback   <= '0;
    end else begin
      readback <= stored;
      if (inval) begin
        stored_vld <= 1'b0;
      end else if (upd) begin
        stored     <= addr;
        stored_vld <= 1'b1;
      end
    end
  end

  // R7
  inval_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inval |=> !stored_vld);

  // R6
  upd_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !inval) |=> (stored == $past(addr)));

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd || inval) |=> $stable(stored));

  // R10
  readback_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (readback == $past(stored)));
endmodule

// File: rtl/dram_page_watch.sv
module dram_page_watch #(
  parameter int ADDR_W     = 32,
  parameter int CODE_W     = 3,
  parameter int BASE_SHIFT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_abort,
  input  logic              acc_done,
  input  logic              acc_bank0,
  input  logic              bus_lost,
  input  logic [CODE_W-1:0] page_code,
  output logic              page_cross,
  output logic              host_req_mask,
  output logic [ADDR_W-1:0] last_addr
);
  import dpw_pkg::*;

  dpw_ctl_t          ctl;
  logic              eligible;
  logic              upd;
  logic              same_page;
  logic              stored_vld;
  logic [ADDR_W-1:0] stored;

  assign ctl = '{valid: acc_valid, abort: acc_abort, done: acc_done, bank0: acc_bank0};

  assign eligible = ctl.valid & ctl.bank0 & ~ctl.abort;
  assign upd      = eligible & ctl.done;

  dpw_page_cmp #(
    .ADDR_W(ADDR_W), .CODE_W(CODE_W), .BASE_SHIFT(BASE_SHIFT)
  ) u_cmp (
    .addr_a(acc_addr), .addr_b(stored), .code(page_code), .same_page(same_page)
  );

  dpw_page_reg #(.ADDR_W(ADDR_W)) u_reg (
    .clk(clk), .rst_n(rst_n), .upd(upd), .inval(bus_lost), .addr(acc_addr),
    .stored(stored), .stored_vld(stored_vld), .readback(last_addr)
  );

  assign page_cross    = eligible & (~stored_vld | ~same_page);
  assign host_req_mask = page_cross;

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> !page_cross);

  // R4
  offbank_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_bank0 |-> !page_cross);

  // R5
  abort_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_abort |-> !page_cross);

  // R9
  mask_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_req_mask == page_cross);

  // R7
  lost_forces_cross_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_lost |=> (!(acc_valid && acc_bank0 && !acc_abort) || page_cross));
endmodule

// File: tb/dram_page_watch_test.sv
module dram_page_watch_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic [31:0] acc_addr = '0;
  logic        acc_abort = 1'b0;
  logic        acc_done = 1'b0;
  logic        acc_bank0 = 1'b0;
  logic        bus_lost = 1'b0;
  logic [2:0]  page_code = 3'd0;
  logic        page_cross;
  logic        host_req_mask;
  logic [31:0] last_addr;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  dram_page_watch uut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_abort(acc_abort), .acc_done(acc_done), .acc_bank0(acc_bank0),
    .bus_lost(bus_lost), .page_code(page_code), .page_cross(page_cross),
    .host_req_mask(host_req_mask), .last_addr(last_addr)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_cross(string req, logic exp);
    check(req, {31'd0, page_cross}, {31'd0, exp});
    check("R9", {31'd0, host_req_mask}, {31'd0, exp});
  endtask

  task automatic idle();
    acc_valid = 0; acc_abort = 0; acc_done = 0; acc_bank0 = 0;
  endtask

  // one-cycle access, completed when done=1
  task automatic access(string req, logic [31:0] a, logic b0, logic ab, logic dn, logic exp);
    @(negedge clk);
    acc_valid = 1; acc_addr = a; acc_bank0 = b0; acc_abort = ab; acc_done = dn;
    #1 check_cross(req, exp);
    @(negedge clk);
    idle();
  endtask

  task automatic t_reset();
    @(negedge clk);
    check_cross("R1", 1'b0);
    check("R1", last_addr, 32'h0);
    access("R1", 32'h100, 1, 0, 1, 1'b1);
  endtask

  task automatic t_same_and_cross();
    access("R2", 32'h1FF, 1, 0, 1, 1'b0);
    access("R3", 32'h200, 1, 0, 1, 1'b1);
    check("R10", last_addr, 32'h1FF);
    @(negedge clk);
    check("R10", last_addr, 32'h200);
  endtask

  task automatic t_offbank();
    access("R4", 32'h5000, 0, 0, 1, 1'b0);
    access("R4", 32'h210, 1, 0, 1, 1'b0);
    @(negedge clk);
    check("R4", last_addr, 32'h210);
  endtask

  task automatic t_abort();
    access("R5", 32'h900, 1, 1, 1, 1'b0);
    @(negedge clk);
    check("R5", last_addr, 32'h210);
    access("R5", 32'h220, 1, 0, 1, 1'b0);
  endtask

  task automatic t_long();
    @(negedge clk);
    acc_valid = 1; acc_addr = 32'h700; acc_bank0 = 1; acc_abort = 0; acc_done = 0;
    for (int k = 0; k < 3; k++) begin
      #1 check_cross("R11", 1'b1);
      @(negedge clk);
    end
    idle();
    #1 check_cross("R11", 1'b0);
    @(negedge clk);
    check("R6", last_addr, 32'h220);
    access("R6", 32'h230, 1, 0, 0, 1'b0);
  endtask

  task automatic t_lost();
    @(negedge clk);
    bus_lost = 1;
    @(negedge clk);
    bus_lost = 0;
    access("R7", 32'h230, 1, 0, 1, 1'b1);
    access("R7", 32'h231, 1, 0, 1, 1'b0);
  endtask

  task automatic t_size();
    page_code = 3'd2;
    access("R8", 32'h3FF, 1, 0, 1, 1'b0);
    access("R8", 32'h400, 1, 0, 1, 1'b1);
    page_code = 3'd7;
    access("R8", 32'h7FFF, 1, 0, 1, 1'b0);
    access("R8", 32'h8000, 1, 0, 1, 1'b1);
    page_code = 3'd0;
    access("R8", 32'h80FF, 1, 0, 1, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_same_and_cross();
    t_offbank();
    t_abort();
    t_long();
    t_lost();
    t_size();
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #100000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule